// File: doc/BRIEF.md
# Countdown Timer Pair with Watchdog

This block gives one processor core two 32-bit down-counters on a 32-bit register bus. Channel 0 is a plain countdown timer that raises a level interrupt each time it reaches zero. Channel 1 works the same way until software sets it into watchdog mode. In that mode, reaching zero raises a reset request in place of an interrupt. Each counter has a prescaler, and either a periodic mode or a one-shot mode.

Watchdog mode is sticky. An ordinary control write cannot clear it. Only two fixed unlock words, written in order to a dedicated disable register, return channel 1 to timer mode. The system reset generator and interrupt routing sit outside this block.

Register writes are single-cycle, selected by `wr_en`. Reads are combinational from `addr` and have no side effects. Channel 0 sits at offset 0x00 and channel 1 at offset 0x20.

Top module: `lcl_cdtimer`

## Requirements
- R1: After reset every register reads zero, watchdog mode is off, and `tmr_irq`, `wd_irq` and `wd_rst_req` are low.
- R2: Channel 0 sits at 0x00 and channel 1 at 0x20. Within a channel, offset 0x00 is the reload value and 0x04 is the current count (read only). Offset 0x08 is control and 0x0C is status. Channel 1 adds reset-status at 0x10 and a disable register at 0x14, which reads as zero. Writing the reload value also copies it into the count.
- R3: Control bits have these meanings:
  - Bit 0: run.
  - Bit 1: periodic.
  - Bit 2: interrupt enable.
  - Bit 3: watchdog mode, channel 1 only (it reads 0 on channel 0).
  - Bits 8 and up: prescaler P, PRE_W bits wide. The count steps once every P+1 clocks while running. Clearing run freezes the count.
- R4: In periodic mode with reload value N, a zero event happens on every (N+1)th step. The step taken at zero reloads N.
- R5: Outside periodic mode, the step taken at zero gives one zero event. The counter then holds 0 and raises no further events until the reload value is written again.
- R6: A zero event sets status bit 0. Writing 1 to status bit 0 clears it, and writing 0 has no effect. A set in the same cycle beats a clear.
- R7: `tmr_irq` is high while channel 0's status bit and interrupt enable are both set. `wd_irq` follows the same rule for channel 1, but only while channel 1 is in timer mode.
- R8: In watchdog mode, a zero event sets reset-status bit 0 and holds `wd_rst_req` high until 1 is written to that bit. `wd_irq` stays low whatever the interrupt enable holds.
- R9: A control write with bit 3 at 0 does not leave watchdog mode. The other control bits still take the written values.
- R10: Writing 0x12345678 and then 0x87654321 to the disable register leaves watchdog mode. Any other disable write between the two cancels the sequence, and the second word on its own has no effect.
- R11: Writing the reload value while counting restarts the countdown from the new value with a fresh prescaler phase. This write beats a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tmr_irq | output | 1 | Channel 0 interrupt |
| wd_irq | output | 1 | Channel 1 interrupt in timer mode |
| wd_rst_req | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with a 16-bit count and a 4-bit prescaler. Small reload values of 0 to 9 and a prescaler of 2 then produce every zero event within a few clocks. This keeps the exact cycle of each step, reload and one-shot halt inside a short, fully predicted window. The prescaler case shows the hold between steps at a known phase. Zero-value reloads cover the event on every step. The watchdog sequence covers entry, sticky mode, the reset-request level, and the unlock order with an intervening stray word.

// File: rtl/lcl_cdtimer.sv
module lcl_cdtimer #(
  parameter int          CNT_W = 32,
  parameter int          PRE_W = 8,
  parameter logic [31:0] KEY_A = 32'h1234_5678,
  parameter logic [31:0] KEY_B = 32'h8765_4321
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        tmr_irq,
  output logic        wd_irq,
  output logic        wd_rst_req
);
  localparam logic [4:0] O_LOAD = 5'h00;
  localparam logic [4:0] O_CNT  = 5'h04;
  localparam logic [4:0] O_CTL  = 5'h08;
  localparam logic [4:0] O_STS  = 5'h0C;
  localparam logic [4:0] O_RST  = 5'h10;
  localparam logic [4:0] O_DIS  = 5'h14;

  logic [1:0][CNT_W-1:0] ld_q, cnt_q;
  logic [1:0][PRE_W-1:0] psc_q, pdiv_q;
  logic [1:0] en_q, per_q, ie_q, flag_q, halt_q;
  logic [1:0] wsel, run, tick, zev;
  logic       wdm_q, rflag_q, armed_q;

  wire [4:0] off = addr[4:0];
  wire       ch  = addr[5];

  assign wsel = {wr_en & ch, wr_en & ~ch};
  assign run  = en_q & ~halt_q;

  always_comb
    for (int i = 0; i < 2; i++) begin
      tick[i] = run[i] && (pdiv_q[i] == psc_q[i]);
      zev[i]  = tick[i] && (cnt_q[i] == '0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_q   <= '0;
      cnt_q  <= '0;
      psc_q  <= '0;
      pdiv_q <= '0;
      en_q   <= '0;
      per_q  <= '0;
      ie_q   <= '0;
      flag_q <= '0;
      halt_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (run[i]) pdiv_q[i] <= tick[i] ? '0 : pdiv_q[i] + 1'b1;
        if (tick[i]) begin
          if (cnt_q[i] != '0)  cnt_q[i] <= cnt_q[i] - 1'b1;
          else if (per_q[i])   cnt_q[i] <= ld_q[i];
          else                 halt_q[i] <= 1'b1;
        end
        if (wsel[i] && off == O_CTL) begin
          en_q[i]  <= wdata[0];
          per_q[i] <= wdata[1];
          ie_q[i]  <= wdata[2];
          psc_q[i] <= wdata[8 +: PRE_W];
        end
        if (wsel[i] && off == O_STS && wdata[0]) flag_q[i] <= 1'b0;
        if (zev[i]) flag_q[i] <= 1'b1;
        if (wsel[i] && off == O_LOAD) begin
          ld_q[i]   <= wdata[CNT_W-1:0];
          cnt_q[i]  <= wdata[CNT_W-1:0];
          pdiv_q[i] <= '0;
          halt_q[i] <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wdm_q   <= 1'b0;
      rflag_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wsel[1] && off == O_CTL && wdata[3]) wdm_q <= 1'b1;
      if (wsel[1] && off == O_DIS) begin
        armed_q <= (wdata == KEY_A);
        if (armed_q && wdata == KEY_B) wdm_q <= 1'b0;
      end
      if (wsel[1] && off == O_RST && wdata[0]) rflag_q <= 1'b0;
      if (zev[1] && wdm_q) rflag_q <= 1'b1;
    end

  always_comb begin
    rdata = '0;
    case (off)
      O_LOAD:  rdata = 32'(ld_q[ch]);
      O_CNT:   rdata = 32'(cnt_q[ch]);
      O_CTL:   rdata = 32'({psc_q[ch], 4'b0000, ch & wdm_q, ie_q[ch], per_q[ch], en_q[ch]});
      O_STS:   rdata = {31'b0, flag_q[ch]};
      O_RST:   rdata = {31'b0, ch & rflag_q};
      default: rdata = '0;
    endcase
  end

  assign tmr_irq    = flag_q[0] & ie_q[0];
  assign wd_irq     = flag_q[1] & ie_q[1] & ~wdm_q;
  assign wd_rst_req = rflag_q;
endmodule

// File: rtl/lcl_cdtimer_chk.sv
module lcl_cdtimer_chk #(
  parameter int          CNT_W = 32,
  parameter logic [31:0] KEY_B = 32'h8765_4321
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [5:0]       addr,
  input logic [31:0]      wdata,
  input logic [CNT_W-1:0] cnt0,
  input logic             halt0,
  input logic             wdm,
  input logic             armed,
  input logic             wd_irq,
  input logic             wd_rst_req
);
  wire ld0_wr = wr_en && addr == 6'h00;

  // R9
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 6'h28 && !wdata[3] && wdm |=> wdm);

  // R10
  lone_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 6'h34 && wdata == KEY_B && !armed |=> wdm == $past(wdm));

  // R11
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld0_wr |=> cnt0 == $past(wdata[CNT_W-1:0]));

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt0 && !ld0_wr |=> $stable(cnt0) && cnt0 == '0);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld0_wr && cnt0 != '0 |=> cnt0 == $past(cnt0) || cnt0 == $past(cnt0) - 1'b1);

  // R8
  rst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_req) |-> $past(wdm));

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdm && $past(wdm) |-> !wd_irq);
endmodule

bind lcl_cdtimer lcl_cdtimer_chk #(.CNT_W(CNT_W), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt0(cnt_q[0]), .halt0(halt_q[0]), .wdm(wdm_q), .armed(armed_q),
  .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
);

// File: tb/lcl_cdtimer_test.sv
module lcl_cdtimer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tmr_irq, wd_irq, wd_rst_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] q_exp[$];
  int          q_sel[$];
  string       q_tag[$];
  event        sample_ev;

  always #10 clk = ~clk;

  lcl_cdtimer #(.CNT_W(16), .PRE_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tmr_irq(tmr_irq), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
  );

  always @(sample_ev) begin
    while (q_exp.size() > 0) begin
      logic [31:0] e, a;
      int s;
      string t;
      e = q_exp.pop_front();
      s = q_sel.pop_front();
      t = q_tag.pop_front();
      case (s)
        0: a = rdata;
        1: a = {31'b0, tmr_irq};
        2: a = {31'b0, wd_irq};
        default: a = {31'b0, wd_rst_req};
      endcase
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s sel=%0d addr=%h actual=%h expected=%h", t, s, addr, a, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input logic [5:0] a, input logic [31:0] e, input int sel, input string tag);
    addr = a;
    #1;
    q_exp.push_back(e); q_sel.push_back(sel); q_tag.push_back(tag);
    -> sample_ev;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    expect_item(a, e, 0, tag);
  endtask

  task automatic pin(input int sel, input logic e, input string tag);
    expect_item(addr, {31'b0, e}, sel, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(6'h00, 0, "R1"); rd(6'h04, 0, "R1"); rd(6'h08, 0, "R1"); rd(6'h0C, 0, "R1");
    rd(6'h20, 0, "R1"); rd(6'h28, 0, "R1"); rd(6'h30, 0, "R1");
    pin(1, 0, "R1"); pin(2, 0, "R1"); pin(3, 0, "R1");

    // R2 map and load copy
    wr(6'h00, 5);
    wr(6'h20, 7);
    rd(6'h04, 5, "R2"); rd(6'h24, 7, "R2"); rd(6'h00, 5, "R2");
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h34, 0, "R2");

    // R3 stopped, then prescaler 2
    idle(5);
    rd(6'h04, 5, "R3");
    wr(6'h08, 32'h0000_0201);
    rd(6'h08, 32'h0000_0201, "R3");
    idle(2); rd(6'h04, 5, "R3");
    idle(1); rd(6'h04, 4, "R3");
    idle(2); rd(6'h04, 4, "R3");
    idle(1); rd(6'h04, 3, "R3");
    wr(6'h08, 32'h0000_0008);
    rd(6'h08, 0, "R3");
    idle(4); rd(6'h04, 3, "R3");

    // R5 one-shot, R6/R7 status and interrupt
    wr(6'h00, 2);
    wr(6'h08, 32'h5);
    rd(6'h04, 2, "R5");
    idle(2); rd(6'h04, 0, "R5"); rd(6'h0C, 0, "R6"); pin(1, 0, "R7");
    idle(1); rd(6'h0C, 1, "R6"); pin(1, 1, "R7");
    idle(10); rd(6'h04, 0, "R5");
    wr(6'h0C, 0);
    rd(6'h0C, 1, "R6");
    wr(6'h0C, 1);
    rd(6'h0C, 0, "R6"); pin(1, 0, "R7");
    idle(6); rd(6'h0C, 0, "R5"); rd(6'h04, 0, "R5");

    // R4 periodic
    wr(6'h08, 0);
    wr(6'h00, 3);
    wr(6'h08, 32'h3);
    rd(6'h04, 3, "R4");
    idle(3); rd(6'h04, 0, "R4"); rd(6'h0C, 0, "R4");
    idle(1); rd(6'h0C, 1, "R4"); rd(6'h04, 3, "R4");
    wr(6'h0C, 1);
    rd(6'h0C, 0, "R4"); rd(6'h04, 1, "R4");
    idle(1); rd(6'h0C, 0, "R4"); rd(6'h04, 0, "R4");
    idle(1); rd(6'h0C, 1, "R4"); rd(6'h04, 3, "R4");

    // R11 reload while counting
    idle(1);
    wr(6'h00, 9);
    rd(6'h04, 9, "R11");
    idle(1); rd(6'h04, 8, "R11");
    wr(6'h08, 0);
    wr(6'h0C, 1);

    // R7 channel 1 in timer mode
    wr(6'h20, 1);
    wr(6'h28, 32'h7);
    idle(1); pin(2, 0, "R7");
    idle(1); pin(2, 1, "R7"); rd(6'h2C, 1, "R7"); rd(6'h30, 0, "R8"); pin(3, 0, "R8");
    wr(6'h28, 0);
    wr(6'h2C, 1);
    pin(2, 0, "R7");

    // R8 watchdog mode
    wr(6'h28, 32'h0000_000C);
    rd(6'h28, 32'h0000_000C, "R3");
    wr(6'h20, 2);
    wr(6'h28, 32'h0000_000D);
    idle(2); pin(3, 0, "R8");
    idle(1); pin(3, 1, "R8"); rd(6'h30, 1, "R8"); pin(2, 0, "R8"); rd(6'h2C, 1, "R8");

    // R9 sticky mode
    wr(6'h28, 0);
    rd(6'h28, 32'h8, "R9"); pin(3, 1, "R9");
    wr(6'h30, 1);
    rd(6'h30, 0, "R8"); pin(3, 0, "R8");
    wr(6'h2C, 1);

    // R10 unlock sequence
    wr(6'h34, 32'h8765_4321);
    rd(6'h28, 32'h8, "R10");
    wr(6'h34, 32'h1234_5678);
    wr(6'h34, 32'h0000_DEAD);
    wr(6'h34, 32'h8765_4321);
    rd(6'h28, 32'h8, "R10");
    wr(6'h34, 32'h1234_5678);
    wr(6'h34, 32'h8765_4321);
    rd(6'h28, 0, "R10");

    // R7/R8 back in timer mode: zero reload fires on first step
    wr(6'h20, 0);
    wr(6'h28, 32'h5);
    idle(1); pin(2, 1, "R7"); pin(3, 0, "R8"); rd(6'h30, 0, "R8");

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL all watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule